// File: doc/BRIEF.md
# Belt Operand Storage

This block holds operand values on a belt: a short ordered row of value slots where the newest value always sits at the front. Instructions do not name a destination. A producing operation drops one or two results onto the front of the belt, and every value already there moves back by the same number of places. Consumers name their operands by distance from the front, so position 0 is the most recent result, position 1 the one before it, and so on. A value that is pushed past the last slot is lost.

Two read ports look up belt positions combinationally and return the contents as they stand before any drop in the same cycle. Each slot carries a valid bit, cleared at reset. A read of a slot that has never been filled raises a per-port error flag. The block also reports how many slots hold valid values.

Top module: `belt_store`

## Requirements
- R1: After reset every slot is invalid, `validCount` is 0, `slotValid` is all zeros and both read error flags are high.
- R2: A read at position p returns the value that was dropped p places before the newest one, where position 0 is the newest.
- R3: When `dropNum` is 1, `dropData` bits [31:0] appear at position 0 after the clock edge, and every earlier value moves back by one position.
- R4: When `dropNum` is 2, `dropData` bits [31:0] take position 0, bits [63:32] take position 1, and every earlier value moves back by two positions.
- R5: Values moved past position 7 are discarded; after more than 8 drops, position 7 holds the 8th newest value.
- R6: The read ports return the belt contents from before the drop in the same cycle.
- R7: Each read error flag is high exactly when its position addresses a slot that is not valid.
- R8: `slotValid` bit i is 1 exactly when at least i+1 values have been dropped since reset, so the valid slots form a run from position 0.
- R9: `validCount` equals the number of values dropped since reset, saturating at 8.
- R10: A `dropNum` of 0 or 3 changes no slot, no valid bit and no count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| dropNum | input | 2 | Number of results dropped this cycle: 0 none, 1 one, 2 two, 3 ignored |
| dropData | input | 64 | Results: [31:0] result 0, [63:32] result 1 |
| rdPos0 | input | 3 | Belt position read by port 0 |
| rdPos1 | input | 3 | Belt position read by port 1 |
| rdData0 | output | 32 | Value at `rdPos0` |
| rdData1 | output | 32 | Value at `rdPos1` |
| rdErr0 | output | 1 | Port 0 addresses an invalid slot |
| rdErr1 | output | 1 | Port 1 addresses an invalid slot |
| slotValid | output | 8 | Valid bit per position, bit 0 is the front |
| validCount | output | 4 | Number of valid slots, 0 to 8 |

## Verification
A slot register that shifts by the wrong amount shows up on the very next read of any position behind the front, since every older value then sits one place off from where the dropped sequence puts it. A valid bit or count that drifts from the number of drops appears on `slotValid`, `validCount` and the error flags in the cycle after the faulty drop. Each stimulus cycle compares both read ports, the valid mask and the count against a model of the belt, so a fault is caught within one cycle of its first effect.

// File: rtl/belt_pkg.sv
package belt_pkg;
  localparam int SHIFT_W = 4;

  typedef struct packed {
    logic               shiftEn;
    logic [SHIFT_W-1:0] shiftBy;
  } belt_ctrl_t;
endpackage

// File: rtl/belt_ctrl.sv
module belt_ctrl
  import belt_pkg::*;
#(
  parameter int SLOTS     = 8,
  parameter int MAX_DROPS = 2,
  localparam int POS_W    = $clog2(SLOTS),
  localparam int NUM_W    = $clog2(MAX_DROPS + 1),
  localparam int CNT_W    = $clog2(SLOTS + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [NUM_W-1:0] dropNum,
  input  logic [POS_W-1:0] rdPos0,
  input  logic [POS_W-1:0] rdPos1,
  output belt_ctrl_t       ctrl,
  output logic [SLOTS-1:0] validQ,
  output logic [CNT_W-1:0] countQ,
  output logic             rdErr0,
  output logic             rdErr1
);
  logic             accept;
  logic [SLOTS-1:0] validNxt;
  logic [CNT_W:0]   countSum;
  logic [CNT_W-1:0] countNxt;

  // a drop is taken only for a legal, non-zero count
  assign accept = (dropNum != '0) && (int'(dropNum) <= MAX_DROPS);

  always_comb begin
    ctrl.shiftEn = accept;
    ctrl.shiftBy = accept ? SHIFT_W'(dropNum) : '0;
  end

  always_comb begin
    validNxt = validQ;
    if (accept)
      validNxt = (validQ << dropNum) | ~({SLOTS{1'b1}} << dropNum);
  end

  always_comb begin
    countSum = {1'b0, countQ} + (CNT_W + 1)'(dropNum);
    countNxt = countQ;
    if (accept)
      countNxt = (countSum >= (CNT_W + 1)'(SLOTS)) ? CNT_W'(SLOTS) : countSum[CNT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ <= '0;
      countQ <= '0;
    end else begin
      validQ <= validNxt;
      countQ <= countNxt;
    end
  end

  assign rdErr0 = !validQ[rdPos0];
  assign rdErr1 = !validQ[rdPos1];

  // R9: the count register tracks the valid mask kept beside it
  a_r9_count_matches: assert property (@(posedge clk) disable iff (!rstN)
    int'(countQ) == $countones(validQ));

  // R8: valid slots always form a run starting at the front
  a_r8_valid_prefix: assert property (@(posedge clk) disable iff (!rstN)
    ((validQ + 1'b1) & validQ) == '0);

  // R10: an ignored drop count leaves the valid mask alone
  a_r10_ignore_mask: assert property (@(posedge clk) disable iff (!rstN)
    (int'(dropNum) > MAX_DROPS) |=> $stable(validQ));

  // R9: count never falls while the block runs
  a_r9_no_decrease: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> countQ >= $past(countQ));
endmodule

// File: rtl/belt_data.sv
module belt_data
  import belt_pkg::*;
#(
  parameter int SLOTS     = 8,
  parameter int WIDTH     = 32,
  parameter int MAX_DROPS = 2,
  localparam int POS_W    = $clog2(SLOTS)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  belt_ctrl_t                ctrl,
  input  logic [MAX_DROPS*WIDTH-1:0] dropData,
  input  logic [POS_W-1:0]          rdPos0,
  input  logic [POS_W-1:0]          rdPos1,
  output logic [WIDTH-1:0]          rdData0,
  output logic [WIDTH-1:0]          rdData1
);
  logic [WIDTH-1:0] slotQ   [SLOTS];
  logic [WIDTH-1:0] slotNxt [SLOTS];
  logic [WIDTH-1:0] dropArr [MAX_DROPS];

  for (genvar d = 0; d < MAX_DROPS; d++) begin : g_unpack
    assign dropArr[d] = dropData[d*WIDTH +: WIDTH];
  end

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    logic [WIDTH-1:0] cand [MAX_DROPS+1];
    for (genvar k = 0; k <= MAX_DROPS; k++) begin : g_shift
      if (i < k) begin : g_fresh
        assign cand[k] = dropArr[i];
      end else begin : g_older
        assign cand[k] = slotQ[i-k];
      end
    end

    always_comb begin
      slotNxt[i] = slotQ[i];
      for (int k = 1; k <= MAX_DROPS; k++)
        if (ctrl.shiftEn && int'(ctrl.shiftBy) == k) slotNxt[i] = cand[k];
    end

    always_ff @(posedge clk) begin
      if (!rstN) slotQ[i] <= '0;
      else       slotQ[i] <= slotNxt[i];
    end
  end

  // reads see the registers, so they return pre-drop contents (R6)
  assign rdData0 = slotQ[rdPos0];
  assign rdData1 = slotQ[rdPos1];

  // R3: a single drop lands at the front, the old front moves back one
  a_r3_single_front: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.shiftEn && ctrl.shiftBy == 1) |=>
      (slotQ[0] == $past(dropArr[0])) && (slotQ[1] == $past(slotQ[0])));

  // R4: a double drop fills the first two slots and moves old values back two
  a_r4_double_order: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.shiftEn && ctrl.shiftBy == 2) |=>
      (slotQ[0] == $past(dropArr[0])) && (slotQ[1] == $past(dropArr[1])) &&
      (slotQ[2] == $past(slotQ[0])));

  // R5: the last slot receives what sat just ahead of it
  a_r5_tail_shift: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.shiftEn && ctrl.shiftBy == 1) |=> slotQ[SLOTS-1] == $past(slotQ[SLOTS-2]));

  // R10: without a shift strobe the belt holds still
  a_r10_hold: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.shiftEn |=> (slotQ[0] == $past(slotQ[0])) && (slotQ[SLOTS-1] == $past(slotQ[SLOTS-1])));
endmodule

// File: rtl/belt_store.sv
module belt_store
  import belt_pkg::*;
#(
  parameter int SLOTS     = 8,
  parameter int WIDTH     = 32,
  parameter int MAX_DROPS = 2,
  localparam int POS_W    = $clog2(SLOTS),
  localparam int NUM_W    = $clog2(MAX_DROPS + 1),
  localparam int CNT_W    = $clog2(SLOTS + 1)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [NUM_W-1:0]           dropNum,
  input  logic [MAX_DROPS*WIDTH-1:0] dropData,
  input  logic [POS_W-1:0]           rdPos0,
  input  logic [POS_W-1:0]           rdPos1,
  output logic [WIDTH-1:0]           rdData0,
  output logic [WIDTH-1:0]           rdData1,
  output logic                       rdErr0,
  output logic                       rdErr1,
  output logic [SLOTS-1:0]           slotValid,
  output logic [CNT_W-1:0]           validCount
);
  belt_ctrl_t ctrl;

  belt_ctrl #(.SLOTS(SLOTS), .MAX_DROPS(MAX_DROPS)) u_ctrl (
    .clk(clk), .rstN(rstN), .dropNum(dropNum), .rdPos0(rdPos0), .rdPos1(rdPos1),
    .ctrl(ctrl), .validQ(slotValid), .countQ(validCount),
    .rdErr0(rdErr0), .rdErr1(rdErr1)
  );

  belt_data #(.SLOTS(SLOTS), .WIDTH(WIDTH), .MAX_DROPS(MAX_DROPS)) u_data (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .dropData(dropData),
    .rdPos0(rdPos0), .rdPos1(rdPos1), .rdData0(rdData0), .rdData1(rdData1)
  );

  // R7: an error on a read port means that slot is not yet valid
  a_r7_err_front: assert property (@(posedge clk) disable iff (!rstN)
    (rdPos0 == '0 && validCount != '0) |-> !rdErr0);
endmodule

// File: tb/belt_store_tb.sv
`timescale 1ns/1ps
module belt_store_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  dropNum = '0;
  logic [63:0] dropData = '0;
  logic [2:0]  rdPos0 = '0, rdPos1 = '0;
  logic [31:0] rdData0, rdData1;
  logic        rdErr0, rdErr1;
  logic [7:0]  slotValid;
  logic [3:0]  validCount;

  int total = 0;
  int bad = 0;
  logic [31:0] mq [8];
  int mcnt = 0;

  always #4 clk = ~clk;

  belt_store u_dut (
    .clk(clk), .rstN(rstN), .dropNum(dropNum), .dropData(dropData),
    .rdPos0(rdPos0), .rdPos1(rdPos1), .rdData0(rdData0), .rdData1(rdData1),
    .rdErr0(rdErr0), .rdErr1(rdErr1), .slotValid(slotValid), .validCount(validCount)
  );

  // {dropNum, data0, data1, rdPos0, rdPos1}
  localparam logic [71:0] VEC [16] = '{
    {2'd1, 32'hA000_0001, 32'h0,         3'd0, 3'd1},
    {2'd2, 32'hB000_0001, 32'hB000_0002, 3'd0, 3'd2},
    {2'd1, 32'hC000_0001, 32'h0,         3'd0, 3'd1},
    {2'd0, 32'hDEAD_0000, 32'hDEAD_0001, 3'd1, 3'd3},
    {2'd3, 32'hEEEE_0000, 32'hEEEE_0001, 3'd2, 3'd3},
    {2'd2, 32'h1111_0000, 32'h1111_0001, 3'd3, 3'd4},
    {2'd1, 32'h2222_0000, 32'h0,         3'd0, 3'd5},
    {2'd2, 32'h3333_0000, 32'h3333_0001, 3'd6, 3'd1},
    {2'd0, 32'h0,         32'h0,         3'd7, 3'd0},
    {2'd1, 32'h4444_0000, 32'h0,         3'd7, 3'd2},
    {2'd2, 32'h5555_0000, 32'h5555_0001, 3'd7, 3'd6},
    {2'd3, 32'h6666_0000, 32'h6666_0001, 3'd0, 3'd7},
    {2'd1, 32'h7777_0000, 32'h0,         3'd1, 3'd7},
    {2'd2, 32'h8888_0000, 32'h8888_0001, 3'd2, 3'd5},
    {2'd0, 32'h0,         32'h0,         3'd0, 3'd1},
    {2'd1, 32'h9999_0000, 32'h0,         3'd4, 3'd7}
  };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic checkPort(input logic [2:0] p, input logic [31:0] d, input logic e);
    chk("R7 error flag", 32'(e), 32'(p >= 3'(mcnt) && mcnt < 8 || (mcnt == 0)));
    if (int'(p) < mcnt) chk("R2 R6 read data", d, mq[p]);
  endtask

  task automatic step(input logic [1:0] n, input logic [31:0] a, input logic [31:0] b,
                      input logic [2:0] p0, input logic [2:0] p1);
    logic [8:0] expMask;
    @(negedge clk);
    dropNum = n; dropData = {b, a}; rdPos0 = p0; rdPos1 = p1;
    #1;
    checkPort(p0, rdData0, rdErr0);
    checkPort(p1, rdData1, rdErr1);
    expMask = (9'd1 << mcnt) - 9'd1;
    chk("R8 valid mask", 32'(slotValid), 32'(expMask[7:0]));
    chk("R9 count", 32'(validCount), 32'(mcnt));
    @(posedge clk);
    if (n == 2'd1) begin
      for (int i = 7; i > 0; i--) mq[i] = mq[i-1];
      mq[0] = a;
    end else if (n == 2'd2) begin
      for (int i = 7; i > 1; i--) mq[i] = mq[i-2];
      mq[0] = a; mq[1] = b;
    end
    if (n == 2'd1 || n == 2'd2) mcnt = (mcnt + int'(n) > 8) ? 8 : mcnt + int'(n);
  endtask

  initial begin
    #(200000 * 8);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) mq[i] = '0;
    dropNum = 2'd2; dropData = 64'hFFFF_FFFF_FFFF_FFFF;
    repeat (3) @(posedge clk);
    @(negedge clk);
    dropNum = '0; rdPos0 = 3'd0; rdPos1 = 3'd7;
    @(negedge clk);
    #1;
    chk("R1 count after reset", 32'(validCount), 32'd0);
    chk("R1 mask after reset", 32'(slotValid), 32'd0);
    chk("R1 err0 after reset", 32'(rdErr0), 32'd1);
    chk("R1 err1 after reset", 32'(rdErr1), 32'd1);
    rstN = 1'b1;

    for (int v = 0; v < 16; v++)
      step(VEC[v][71:70], VEC[v][69:38], VEC[v][37:6], VEC[v][5:3], VEC[v][2:0]);

    // R5: long run of single drops, older values fall off the end
    for (int i = 0; i < 12; i++) step(2'd1, 32'hF000_0000 + 32'(i), 32'h0, 3'd7, 3'd0);
    step(2'd0, 32'h0, 32'h0, 3'd7, 3'd6);
    @(negedge clk); #1;
    chk("R5 tail holds 8th newest", rdData0, 32'hF000_0004);

    // R10: ignored count leaves everything intact
    step(2'd3, 32'hABAB_ABAB, 32'hCDCD_CDCD, 3'd0, 3'd1);
    step(2'd0, 32'h0, 32'h0, 3'd0, 3'd1);
    @(negedge clk); #1;
    chk("R10 front unchanged", rdData0, 32'hF000_000B);

    // R4 R6: double drop, read in same cycle sees old front
    @(negedge clk);
    dropNum = 2'd2; dropData = {32'h0BBB_0001, 32'h0AAA_0000}; rdPos0 = 3'd0; rdPos1 = 3'd1;
    #1;
    chk("R6 pre-drop read", rdData0, 32'hF000_000B);
    @(negedge clk);
    dropNum = '0; #1;
    chk("R4 result0 at front", rdData0, 32'h0AAA_0000);
    chk("R4 result1 at second", rdData1, 32'h0BBB_0001);
    rdPos0 = 3'd2; #1;
    chk("R4 old front moved two", rdData0, 32'hF000_000B);

    // R1: reset again clears validity
    rstN = 1'b0;
    @(negedge clk); #1;
    chk("R1 count after second reset", 32'(validCount), 32'd0);
    chk("R3 R7 err after second reset", 32'(rdErr0), 32'd1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule